// File: doc/BRIEF.md
# SRAM Write-Protection Guard

This block sits in front of a single-port SRAM. Two bus masters share the memory: a CPU port and a DMA port. A 32-bit protection mask divides the low part of the address space into 32 equal regions, one mask bit per region. A write into a region whose bit is set never reaches the memory. The requesting port gets an error response instead, and a sticky violation record latches the address and the master that caused it. Reads are never blocked. Every granted access completes with zero wait states.

Region size follows the memory size. A memory of 32 KB or more gives 1 KB regions that cover only the lowest 32 KB, and writes at or above byte address 32768 are never checked. A smaller memory has the 32 regions spread evenly over the whole memory, so each region is MEM_BYTES/32 bytes. Software can reload the mask at any time through a small configuration write port. The same port clears the violation record. When both masters request in the same cycle, the CPU is served first and the DMA request waits.

Top module: `sram_wp_guard`

## Requirements
- R1: A granted access is answered exactly one cycle after its request cycle with `*_rvalid`=1. A read returns the current word at `addr[MEM_LOG2-1:2]`, which holds the last data written there.
- R2: A write whose byte address falls in a protected region leaves the memory unchanged and is answered with `*_err`=1.
- R3: For a memory smaller than 32 KB, mask bit k protects byte addresses from k*MEM_BYTES/32 up to (k+1)*MEM_BYTES/32-1. With the default 4 KB memory this is `addr[11:7]`. For a memory of 32 KB or more, bit k protects the 1 KB at k*1024.
- R4: When both ports request in one cycle, the CPU is granted and the DMA request is stalled. If the DMA holds its request, it is served in the following cycle.
- R5: The first blocked write sets `viol_flag` and records `viol_addr` and `viol_master`, where 0 means CPU and 1 means DMA. Later violations leave the record unchanged while the flag is set. Writing 1 to bit 0 with `cfg_sel`=1 clears the flag. A violation in the same cycle as the clear wins.
- R6: After reset, `wp_mask` is zero and nothing is protected. A write with `cfg_sel`=0 loads `cfg_wdata` into the mask. The new mask applies from the next cycle, while an access in the same cycle as the load is checked against the old mask.
- R7: With `ADDR_W` above 15, writes at byte address 32768 or above are never blocked. The memory index still uses the low address bits.
- R8: The mask applies to DMA writes exactly as to CPU writes.
- R9: The size field encodes 0 as byte, 1 as halfword and 2 as word. Accesses are naturally aligned, and write data sits on its byte lanes. A byte or halfword write updates only its lanes, and protection is decided from its byte address.
- R10: Reads from protected regions complete normally, with no error and with the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_size | input | 2 | CPU access size: 0 byte, 1 half, 2 word |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_wdata | input | 32 | CPU write data, lane aligned |
| cpu_gnt | output | 1 | CPU request accepted this cycle |
| cpu_rvalid | output | 1 | CPU response valid |
| cpu_err | output | 1 | CPU write was blocked |
| cpu_rdata | output | 32 | CPU read data |
| dma_req | input | 1 | DMA access request |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_size | input | 2 | DMA access size |
| dma_addr | input | ADDR_W | DMA byte address |
| dma_wdata | input | 32 | DMA write data, lane aligned |
| dma_gnt | output | 1 | DMA request accepted this cycle |
| dma_rvalid | output | 1 | DMA response valid |
| dma_err | output | 1 | DMA write was blocked |
| dma_rdata | output | 32 | DMA read data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: load mask, 1: violation clear |
| cfg_wdata | input | 32 | Configuration write data |
| wp_mask | output | 32 | Current protection mask |
| viol_flag | output | 1 | Sticky violation flag |
| viol_addr | output | ADDR_W | Address of the recorded violation |
| viol_master | output | 1 | Master of the recorded violation |

## Verification
The assertions check on every cycle that at most one port is granted and that every grant is answered in the next cycle. They also check that a contended cycle answers the CPU alone, that an error response comes only from a write and always goes with a set violation flag, that the flag stays set until a clear, and that the mask changes only on a configuration load and then to the loaded value. The bench scenarios cover what needs stored data or an address map. These are the region boundaries for the 4 KB memory, the unchanged contents after a blocked write, byte-lane merging, the same-cycle mask update using the old mask, the first-violation-only record, and writes above 32 KB that are never blocked.

// File: rtl/sram_wp_pkg.sv
package sram_wp_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;

   typedef enum logic {
      MST_CPU = 1'b0,
      MST_DMA = 1'b1
   } master_e;

   localparam int REGIONS      = 32;
   localparam int REGION_BITS  = 5;
   localparam int WINDOW_LOG2  = 15;   // guarded window is 32 KB
   localparam int DATA_W       = 32;
   localparam int LANES        = DATA_W / 8;

   // lane enables for a naturally aligned access
   function automatic logic [LANES-1:0] lane_enables(input logic [1:0] size,
                                                     input logic [1:0] low);
      logic [LANES-1:0] en;
      case (size)
         SZ_BYTE: en = 4'b0001 << low;
         SZ_HALF: en = low[1] ? 4'b1100 : 4'b0011;
         default: en = 4'b1111;
      endcase
      return en;
   endfunction

endpackage

// File: rtl/wp_arbiter.sv
module wp_arbiter
   import sram_wp_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [1:0]        cpu_size,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              dma_req,
   input  logic              dma_we,
   input  logic [1:0]        dma_size,
   input  logic [ADDR_W-1:0] dma_addr,
   input  logic [DATA_W-1:0] dma_wdata,
   output logic              gnt_cpu,
   output logic              gnt_dma,
   output logic              acc_valid,
   output logic              acc_we,
   output logic [1:0]        acc_size,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [DATA_W-1:0] acc_wdata,
   output master_e           acc_master
);

   // fixed priority: CPU wins any contended cycle
   always_comb begin
      gnt_cpu   = cpu_req;
      gnt_dma   = dma_req & ~cpu_req;
      acc_valid = gnt_cpu | gnt_dma;
      if (gnt_cpu) begin
         acc_we     = cpu_we;
         acc_size   = cpu_size;
         acc_addr   = cpu_addr;
         acc_wdata  = cpu_wdata;
         acc_master = MST_CPU;
      end else begin
         acc_we     = dma_we & dma_req;
         acc_size   = dma_size;
         acc_addr   = dma_addr;
         acc_wdata  = dma_wdata;
         acc_master = MST_DMA;
      end
   end

endmodule

// File: rtl/wp_region_check.sv
module wp_region_check
   import sram_wp_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int MEM_BYTES = 4096
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [REGIONS-1:0] mask,
   output logic               protect
);

   localparam int MEM_LOG2  = $clog2(MEM_BYTES);
   localparam int REGION_LO = (MEM_LOG2 < WINDOW_LOG2) ? (MEM_LOG2 - REGION_BITS) : 10;

   logic                   in_window;
   logic [REGION_BITS-1:0] region;

   assign region = addr[REGION_LO +: REGION_BITS];

   generate
      if (ADDR_W > WINDOW_LOG2) begin : g_wide
         assign in_window = (addr[ADDR_W-1:WINDOW_LOG2] == '0);
      end else begin : g_narrow
         assign in_window = 1'b1;
      end
   endgenerate

   assign protect = in_window & mask[region];

endmodule

// File: rtl/wp_mem.sv
module wp_mem
   import sram_wp_pkg::*;
#(
   parameter int MEM_BYTES = 4096
) (
   input  logic                          clk,
   input  logic                          en,
   input  logic                          we,
   input  logic [LANES-1:0]              be,
   input  logic [$clog2(MEM_BYTES)-3:0]  idx,
   input  logic [DATA_W-1:0]             wdata,
   output logic [DATA_W-1:0]             rdata
);

   localparam int WORDS = MEM_BYTES / LANES;

   logic [DATA_W-1:0] store [WORDS];

   always_ff @(posedge clk) begin
      if (en && !we) rdata <= store[idx];
   end

   generate
      for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
         always_ff @(posedge clk) begin
            if (en && we && be[ln]) store[idx][ln*8 +: 8] <= wdata[ln*8 +: 8];
         end
      end
   endgenerate

endmodule

// File: rtl/wp_violation.sv
module wp_violation
   import sram_wp_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set,
   input  logic [ADDR_W-1:0] set_addr,
   input  master_e           set_master,
   input  logic              clr,
   output logic              flag,
   output logic [ADDR_W-1:0] addr,
   output logic              master
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag   <= 1'b0;
         addr   <= '0;
         master <= 1'b0;
      end else if (set && (!flag || clr)) begin
         flag   <= 1'b1;
         addr   <= set_addr;
         master <= set_master;
      end else if (clr) begin
         flag   <= 1'b0;
      end
   end

endmodule

// File: rtl/sram_wp_guard.sv
module sram_wp_guard
   import sram_wp_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int MEM_BYTES = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [1:0]        cpu_size,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [31:0]       cpu_wdata,
   output logic              cpu_gnt,
   output logic              cpu_rvalid,
   output logic              cpu_err,
   output logic [31:0]       cpu_rdata,
   input  logic              dma_req,
   input  logic              dma_we,
   input  logic [1:0]        dma_size,
   input  logic [ADDR_W-1:0] dma_addr,
   input  logic [31:0]       dma_wdata,
   output logic              dma_gnt,
   output logic              dma_rvalid,
   output logic              dma_err,
   output logic [31:0]       dma_rdata,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       wp_mask,
   output logic              viol_flag,
   output logic [ADDR_W-1:0] viol_addr,
   output logic              viol_master
);

   localparam int MEM_LOG2 = $clog2(MEM_BYTES);
   localparam int IDX_W    = MEM_LOG2 - 2;

   generate
      if ((1 << MEM_LOG2) != MEM_BYTES) begin : g_bad_pow2
         $error("MEM_BYTES must be a power of two");
      end
      if (MEM_BYTES < 128) begin : g_bad_small
         $error("MEM_BYTES must be at least 128 so each region holds a word");
      end
      if (MEM_LOG2 > ADDR_W) begin : g_bad_addr
         $error("ADDR_W too narrow for MEM_BYTES");
      end
   endgenerate

   logic              acc_valid, acc_we, acc_protect, acc_blocked, mem_en;
   logic [1:0]        acc_size;
   logic [ADDR_W-1:0] acc_addr;
   logic [31:0]       acc_wdata, mem_rdata;
   master_e           acc_master;
   logic              rsp_cpu_q, rsp_dma_q, rsp_err_q;

   wp_arbiter #(.ADDR_W(ADDR_W)) u_arb (
      .cpu_req   (cpu_req),
      .cpu_we    (cpu_we),
      .cpu_size  (cpu_size),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .dma_req   (dma_req),
      .dma_we    (dma_we),
      .dma_size  (dma_size),
      .dma_addr  (dma_addr),
      .dma_wdata (dma_wdata),
      .gnt_cpu   (cpu_gnt),
      .gnt_dma   (dma_gnt),
      .acc_valid (acc_valid),
      .acc_we    (acc_we),
      .acc_size  (acc_size),
      .acc_addr  (acc_addr),
      .acc_wdata (acc_wdata),
      .acc_master(acc_master)
   );

   wp_region_check #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_chk_region (
      .addr    (acc_addr),
      .mask    (wp_mask),
      .protect (acc_protect)
   );

   assign acc_blocked = acc_valid & acc_we & acc_protect;
   assign mem_en      = acc_valid & ~acc_blocked;

   wp_mem #(.MEM_BYTES(MEM_BYTES)) u_mem (
      .clk   (clk),
      .en    (mem_en),
      .we    (acc_we),
      .be    (lane_enables(acc_size, acc_addr[1:0])),
      .idx   (acc_addr[MEM_LOG2-1:2]),
      .wdata (acc_wdata),
      .rdata (mem_rdata)
   );

   wp_violation #(.ADDR_W(ADDR_W)) u_viol (
      .clk        (clk),
      .rst_n      (rst_n),
      .set        (acc_blocked),
      .set_addr   (acc_addr),
      .set_master (acc_master),
      .clr        (cfg_we & cfg_sel & cfg_wdata[0]),
      .flag       (viol_flag),
      .addr       (viol_addr),
      .master     (viol_master)
   );

   // protection mask register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 wp_mask <= '0;
      else if (cfg_we && !cfg_sel) wp_mask <= cfg_wdata;
   end

   // single-cycle response stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_cpu_q <= 1'b0;
         rsp_dma_q <= 1'b0;
         rsp_err_q <= 1'b0;
      end else begin
         rsp_cpu_q <= cpu_gnt;
         rsp_dma_q <= dma_gnt;
         rsp_err_q <= acc_blocked;
      end
   end

   assign cpu_rvalid = rsp_cpu_q;
   assign dma_rvalid = rsp_dma_q;
   assign cpu_err    = rsp_cpu_q & rsp_err_q;
   assign dma_err    = rsp_dma_q & rsp_err_q;
   assign cpu_rdata  = mem_rdata;
   assign dma_rdata  = mem_rdata;

   logic [IDX_W-1:0] unused_idx_w;
   assign unused_idx_w = '0;

endmodule

// File: rtl/wp_guard_checker.sv
module wp_guard_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        cpu_req,
   input logic        cpu_we,
   input logic        cpu_gnt,
   input logic        cpu_rvalid,
   input logic        cpu_err,
   input logic        dma_req,
   input logic        dma_we,
   input logic        dma_gnt,
   input logic        dma_rvalid,
   input logic        dma_err,
   input logic        cfg_we,
   input logic        cfg_sel,
   input logic [31:0] cfg_wdata,
   input logic [31:0] wp_mask,
   input logic        viol_flag
);

   a_r4_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_gnt && dma_gnt));

   a_r4_contention_cpu_first: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && dma_req) |=> (cpu_rvalid && !dma_rvalid));

   a_r1_cpu_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_gnt |=> cpu_rvalid);

   a_r1_dma_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      dma_gnt |=> dma_rvalid);

   a_r2_cpu_err_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rvalid && cpu_err) |-> $past(cpu_we));

   a_r8_dma_err_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_rvalid && dma_err) |-> $past(dma_we));

   a_r5_err_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_err || dma_err) |-> viol_flag);

   a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_flag && !(cfg_we && cfg_sel && cfg_wdata[0])) |=> viol_flag);

   a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_sel) |=> (wp_mask == $past(cfg_wdata)));

   a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(wp_mask));

endmodule

bind sram_wp_guard wp_guard_checker u_wp_guard_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_req    (cpu_req),
   .cpu_we     (cpu_we),
   .cpu_gnt    (cpu_gnt),
   .cpu_rvalid (cpu_rvalid),
   .cpu_err    (cpu_err),
   .dma_req    (dma_req),
   .dma_we     (dma_we),
   .dma_gnt    (dma_gnt),
   .dma_rvalid (dma_rvalid),
   .dma_err    (dma_err),
   .cfg_we     (cfg_we),
   .cfg_sel    (cfg_sel),
   .cfg_wdata  (cfg_wdata),
   .wp_mask    (wp_mask),
   .viol_flag  (viol_flag)
);

// File: tb/sim_sram_wp_guard.sv
`timescale 1ns/1ps
module sim_sram_wp_guard;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 0, cpu_we = 0, dma_req = 0, dma_we = 0;
   logic [1:0]  cpu_size = 0, dma_size = 0;
   logic [15:0] cpu_addr = 0, dma_addr = 0;
   logic [31:0] cpu_wdata = 0, dma_wdata = 0;
   logic        cfg_we = 0, cfg_sel = 0;
   logic [31:0] cfg_wdata = 0;
   logic        cpu_gnt, cpu_rvalid, cpu_err, dma_gnt, dma_rvalid, dma_err;
   logic [31:0] cpu_rdata, dma_rdata, wp_mask;
   logic        viol_flag, viol_master;
   logic [15:0] viol_addr;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   sram_wp_guard #(.ADDR_W(16), .MEM_BYTES(4096)) u0 (.*);

   typedef struct packed {
      logic        m;
      logic        we;
      logic [1:0]  sz;
      logic [15:0] a;
      logic [31:0] d;
      logic        e;
      logic [31:0] rd;
   } vec_t;

   // mask 0x5 protects 0x000-0x07F and 0x100-0x17F (128-byte regions)
   localparam vec_t VEC [12] = '{
      '{1'b0, 1'b1, 2'd2, 16'h0080, 32'hDEADBEEF, 1'b0, 32'h0},
      '{1'b0, 1'b0, 2'd2, 16'h0080, 32'h0,        1'b0, 32'hDEADBEEF},
      '{1'b0, 1'b1, 2'd2, 16'h0000, 32'h11111111, 1'b1, 32'h0},
      '{1'b0, 1'b0, 2'd2, 16'h0000, 32'h0,        1'b0, 32'hCAFEF00D},
      '{1'b1, 1'b1, 2'd0, 16'h017D, 32'h0000AB00, 1'b1, 32'h0},
      '{1'b1, 1'b0, 2'd2, 16'h017C, 32'h0,        1'b0, 32'h12345678},
      '{1'b0, 1'b1, 2'd2, 16'h0180, 32'h0,        1'b0, 32'h0},
      '{1'b1, 1'b1, 2'd0, 16'h0181, 32'h0000CD00, 1'b0, 32'h0},
      '{1'b0, 1'b1, 2'd1, 16'h0182, 32'hBEEF0000, 1'b0, 32'h0},
      '{1'b1, 1'b0, 2'd2, 16'h0180, 32'h0,        1'b0, 32'hBEEFCD00},
      '{1'b0, 1'b1, 2'd0, 16'h007F, 32'hFF000000, 1'b1, 32'h0},
      '{1'b0, 1'b0, 2'd2, 16'h0180, 32'h0,        1'b0, 32'hBEEFCD00}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic m, input logic we, input logic [1:0] sz,
                         input logic [15:0] a, input logic [31:0] d,
                         output logic ok, output logic e, output logic [31:0] rd);
      @(negedge clk);
      if (!m) begin
         cpu_req = 1; cpu_we = we; cpu_size = sz; cpu_addr = a; cpu_wdata = d;
      end else begin
         dma_req = 1; dma_we = we; dma_size = sz; dma_addr = a; dma_wdata = d;
      end
      @(posedge clk);
      @(negedge clk);
      ok = m ? dma_rvalid : cpu_rvalid;
      e  = m ? dma_err : cpu_err;
      rd = m ? dma_rdata : cpu_rdata;
      cpu_req = 0; dma_req = 0;
   endtask

   task automatic cfg_write(input logic sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      logic ok, e;
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      // R6: reset state
      check("R6 reset mask", wp_mask, 32'h0);
      check("R5 reset flag", {31'b0, viol_flag}, 32'h0);
      check("R1 reset rvalid", {30'b0, cpu_rvalid, dma_rvalid}, 32'h0);
      rst_n = 1;
      @(negedge clk);

      // preload with nothing protected (R6)
      run_op(0, 1, 2, 16'h0000, 32'hCAFEF00D, ok, e, rd);
      check("R6 unprotected write after reset", {31'b0, e}, 32'h0);
      run_op(1, 1, 2, 16'h017C, 32'h12345678, ok, e, rd);
      check("R8 dma write unprotected", {30'b0, ok, e}, 32'h2);

      cfg_write(0, 32'h0000_0005);
      check("R6 mask loaded", wp_mask, 32'h5);

      // vector table: R1 R2 R3 R8 R9 R10
      for (int i = 0; i < 12; i++) begin
         run_op(VEC[i].m, VEC[i].we, VEC[i].sz, VEC[i].a, VEC[i].d, ok, e, rd);
         check($sformatf("R1 vec%0d rvalid", i), {31'b0, ok}, 32'h1);
         check($sformatf("R2/R3 vec%0d err", i), {31'b0, e}, {31'b0, VEC[i].e});
         if (!VEC[i].we) check($sformatf("R9/R10 vec%0d rdata", i), rd, VEC[i].rd);
      end

      // R5: first violation recorded (vec2, CPU at 0x0000)
      check("R5 flag set", {31'b0, viol_flag}, 32'h1);
      check("R5 first addr kept", {16'b0, viol_addr}, 32'h0);
      check("R5 master cpu", {31'b0, viol_master}, 32'h0);
      cfg_write(1, 32'h1);
      check("R5 flag cleared", {31'b0, viol_flag}, 32'h0);

      // R6: mask load and access in the same cycle use the old mask
      @(negedge clk);
      cfg_we = 1; cfg_sel = 0; cfg_wdata = 32'h0000_0002;
      cpu_req = 1; cpu_we = 1; cpu_size = 2; cpu_addr = 16'h0080; cpu_wdata = 32'h0BADF00D;
      @(posedge clk);
      @(negedge clk);
      check("R6 same-cycle uses old mask", {30'b0, cpu_rvalid, cpu_err}, 32'h2);
      check("R6 new mask visible", wp_mask, 32'h2);
      cfg_we = 0; cpu_req = 0;
      run_op(0, 1, 2, 16'h0084, 32'h1, ok, e, rd);
      check("R6 new mask applies next cycle", {31'b0, e}, 32'h1);
      check("R5 addr 0x84", {16'b0, viol_addr}, 32'h84);
      // R5: later DMA violation must not overwrite
      run_op(1, 1, 2, 16'h0088, 32'h2, ok, e, rd);
      check("R8 dma blocked", {31'b0, e}, 32'h1);
      check("R5 record sticky addr", {16'b0, viol_addr}, 32'h84);
      check("R5 record sticky master", {31'b0, viol_master}, 32'h0);
      cfg_write(1, 32'h1);
      run_op(1, 1, 1, 16'h008A, 32'h3, ok, e, rd);
      check("R5 dma recorded", {15'b0, viol_master, viol_addr}, 32'h1008A);
      run_op(0, 0, 2, 16'h0080, 32'h0, ok, e, rd);
      check("R2 blocked writes left memory", rd, 32'h0BADF00D);
      cfg_write(1, 32'h1);

      // R4: contention
      @(negedge clk);
      cpu_req = 1; cpu_we = 1; cpu_size = 2; cpu_addr = 16'h0200; cpu_wdata = 32'hAAAA0001;
      dma_req = 1; dma_we = 1; dma_size = 2; dma_addr = 16'h0204; dma_wdata = 32'hBBBB0002;
      @(posedge clk);
      @(negedge clk);
      check("R4 cpu served first", {30'b0, cpu_rvalid, dma_rvalid}, 32'h2);
      cpu_req = 0;
      @(posedge clk);
      @(negedge clk);
      check("R4 dma served after stall", {30'b0, cpu_rvalid, dma_rvalid}, 32'h1);
      dma_req = 0;
      run_op(1, 0, 2, 16'h0204, 32'h0, ok, e, rd);
      check("R4 dma write landed", rd, 32'hBBBB0002);

      // R7: above 32 KB never blocked (aliases onto region 0)
      cfg_write(0, 32'h0000_0003);
      run_op(0, 1, 2, 16'h8000, 32'h55AA55AA, ok, e, rd);
      check("R7 high write not blocked", {31'b0, e}, 32'h0);
      run_op(0, 0, 2, 16'h0000, 32'h0, ok, e, rd);
      check("R7 alias data", rd, 32'h55AA55AA);
      run_op(0, 1, 2, 16'h0004, 32'h1, ok, e, rd);
      check("R3 low window blocked", {31'b0, e}, 32'h1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule